// File: doc/BRIEF.md
# Sequence and Fragment Tracker

This block sits in a receive path after the header decoder. Whenever its enable input is high for a cycle, it captures the 16-bit sequence-control word of the current frame. It splits the word into a sequence number and a fragment number, and reports on the next clock edge whether the frame follows in order after the last frame it accepted.

It checks the word against the more-fragments and retry bits that the header decoder supplies. It also checks it against a stored copy of the last accepted sequence number, fragment number and more-fragments bit. One sender is assumed. The captured word is always passed on as a reassembly count, together with a flag that marks fragmented traffic. A 4-bit code tells which ordering rule was broken, if any.

Top module: `seqtrk_top`

## Requirements
- R1: After a synchronous reset the outputs reasm_count, frag_flag, err and err_code are zero, and no previous frame is on record.
- R2: On the edge after a cycle with seq_en high, reasm_count equals the ctl_word of that cycle. While seq_en is low, the outputs hold their values and ctl_word is ignored.
- R3: The fragment number is ctl_word[3:0] and the sequence number is ctl_word[15:4]. frag_flag is 1 when more_frag is 1 or the fragment number is nonzero, and 0 otherwise.
- R4: A frame with retry_flag set must carry the same sequence and fragment numbers as the last accepted frame. If it does, the result is code 4'b0000 and the history is unchanged. If it does not, or no frame is on record, the code is 4'b0111.
- R5: A nonzero fragment number raises code 4'b0110 in any of these cases: the last accepted frame had more-fragments at 0, the sequence number differs from the stored one, or the fragment number is not the stored fragment number plus one.
- R6: A fragment number of 0 raises code 4'b0101 when the last accepted frame had more-fragments at 1.
- R7: When the last accepted frame was fragment 15 with more-fragments at 1, the next non-retry frame raises code 4'b1000, because a sequence holds at most 16 fragments.
- R8: A fragment-0 frame with sequence number 0 raises code 4'b1001 when a frame is on record whose sequence number is not 4095.
- R9: err is 1 exactly when err_code is nonzero. A rejected frame leaves the stored history unchanged. A frame that passes all checks with retry_flag at 0 becomes the new history.
- R10: When several rules apply to the same frame, the code is picked in this order: 4'b0111 first, then 4'b1000, then 4'b0101 or 4'b0110, then 4'b1001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_en | input | 1 | High for one cycle per frame; the word is captured in that cycle |
| ctl_word | input | 16 | Sequence-control word: sequence number in [15:4], fragment number in [3:0] |
| more_frag | input | 1 | More-fragments bit from the header decoder |
| retry_flag | input | 1 | Retry bit from the header decoder |
| frag_flag | output | 1 | Frame belongs to fragmented traffic |
| reasm_count | output | 16 | Last captured sequence-control word, for reassembly |
| err | output | 1 | Error present for the last captured frame |
| err_code | output | 4 | Error code for the last captured frame, 0 when none |

## Verification
The overflow check, the restart check and the premature-wrap check can all apply to one frame. This happens when a sixteenth fragment announcing more is followed by a fragment-0 frame with sequence number 0, which the bench sends after a full 16-fragment chain. The expected code there is 4'b1000. A retried frame with a mismatched number is then sent on top of the same overflow history, and 4'b0111 is expected. Because the rejected frames leave the history unchanged, that second case meets the same overflow state as the first.

// File: rtl/seqtrk_pkg.sv
package seqtrk_pkg;

    localparam int SEQ_W     = 12;
    localparam int FRAG_W    = 4;
    localparam int WORD_W    = SEQ_W + FRAG_W;
    localparam int SEQ_MAX   = (1 << SEQ_W) - 1;
    localparam int FRAG_LAST = (1 << FRAG_W) - 1;

    typedef enum logic [3:0] {
        C_NONE    = 4'b0000,
        C_RESTART = 4'b0101,
        C_GAP     = 4'b0110,
        C_RETRY   = 4'b0111,
        C_OVF     = 4'b1000,
        C_WRAP    = 4'b1001
    } code_e;

    // Sequence number sits in the upper bits, fragment number in the lower bits.
    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [FRAG_W-1:0] frag;
    } ctl_t;

    typedef struct packed {
        logic valid;
        logic more;
        ctl_t ctl;
    } hist_t;

    function automatic ctl_t split_word(input logic [WORD_W-1:0] w);
        return ctl_t'(w);
    endfunction

    function automatic logic is_fragmented(input ctl_t c, input logic more);
        return more || (c.frag != '0);
    endfunction

endpackage

// File: rtl/seqtrk_classify.sv
module seqtrk_classify
    import seqtrk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  ctl_t  cur,
    input  logic  retry,
    input  hist_t hist,
    output code_e code
);
    logic              same_ids;
    logic              expect_cont;
    logic [FRAG_W-1:0] next_frag;

    assign same_ids    = hist.valid && (cur == hist.ctl);
    assign expect_cont = hist.valid && hist.more;
    assign next_frag   = hist.ctl.frag + 1'b1;

    always_comb begin
        code = C_NONE;
        if (retry) begin
            code = same_ids ? C_NONE : C_RETRY;
        end else if (expect_cont && (hist.ctl.frag == FRAG_W'(FRAG_LAST))) begin
            code = C_OVF;
        end else if (cur.frag == '0) begin
            if (expect_cont)
                code = C_RESTART;
            else if (hist.valid && (cur.seq == '0) && (hist.ctl.seq != SEQ_W'(SEQ_MAX)))
                code = C_WRAP;
        end else if (!expect_cont || (cur.seq != hist.ctl.seq) || (cur.frag != next_frag)) begin
            code = C_GAP;
        end
    end

    AST_RETRY_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (rst)
        (en && retry && !hist.valid) |-> (code == C_RETRY)); // R4

    AST_OVF_FIRST: assert property (@(posedge clk) disable iff (rst)
        (en && !retry && hist.valid && hist.more && (hist.ctl.frag == FRAG_W'(FRAG_LAST)))
        |-> (code == C_OVF)); // R7

endmodule

// File: rtl/seqtrk_history.sv
module seqtrk_history
    import seqtrk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  upd,
    input  ctl_t  cur,
    input  logic  more,
    output hist_t hist
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (upd) begin
            hist.valid <= 1'b1;
            hist.more  <= more;
            hist.ctl   <= cur;
        end
    end

    AST_WRAP_AT_MAX: assert property (@(posedge clk) disable iff (rst)
        (upd && hist.valid && (cur.frag == '0) && (cur.seq == '0))
        |-> (hist.ctl.seq == SEQ_W'(SEQ_MAX))); // R8

    AST_FRAG_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (upd && (cur.frag != '0)) |-> (hist.valid && hist.more && (cur.seq == hist.ctl.seq))); // R5

endmodule

// File: rtl/seqtrk_outreg.sv
module seqtrk_outreg
    import seqtrk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] word,
    input  logic              flag_in,
    input  code_e             code,
    output logic [WORD_W-1:0] count_q,
    output logic              flag_q,
    output logic              err_q,
    output logic [3:0]        code_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            flag_q  <= 1'b0;
            err_q   <= 1'b0;
            code_q  <= '0;
        end else if (en) begin
            count_q <= word;
            flag_q  <= flag_in;
            err_q   <= (code != C_NONE);
            code_q  <= code;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(count_q) && $stable(code_q) && $stable(flag_q))); // R2

endmodule

// File: rtl/seqtrk_top.sv
module seqtrk_top
    import seqtrk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        seq_en,
    input  logic [15:0] ctl_word,
    input  logic        more_frag,
    input  logic        retry_flag,
    output logic        frag_flag,
    output logic [15:0] reasm_count,
    output logic        err,
    output logic [3:0]  err_code
);
    ctl_t  cur;
    hist_t hist;
    code_e code;
    logic  accept;

    assign cur    = split_word(ctl_word);
    assign accept = seq_en && !retry_flag && (code == C_NONE);

    seqtrk_classify u_classify (
        .clk   (clk),
        .rst   (rst),
        .en    (seq_en),
        .cur   (cur),
        .retry (retry_flag),
        .hist  (hist),
        .code  (code)
    );

    seqtrk_history u_history (
        .clk  (clk),
        .rst  (rst),
        .upd  (accept),
        .cur  (cur),
        .more (more_frag),
        .hist (hist)
    );

    seqtrk_outreg u_outreg (
        .clk     (clk),
        .rst     (rst),
        .en      (seq_en),
        .word    (ctl_word),
        .flag_in (is_fragmented(cur, more_frag)),
        .code    (code),
        .count_q (reasm_count),
        .flag_q  (frag_flag),
        .err_q   (err),
        .code_q  (err_code)
    );

    AST_ERR_CODE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        err == (err_code != 4'b0000)); // R9

    AST_CAPTURE_WORD: assert property (@(posedge clk) disable iff (rst)
        seq_en |=> (reasm_count == $past(ctl_word))); // R2

endmodule

// File: tb/tb_seqtrk_top.sv
module tb_seqtrk_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        seq_en;
    logic [15:0] ctl_word;
    logic        more_frag;
    logic        retry_flag;
    logic        frag_flag;
    logic [15:0] reasm_count;
    logic        err;
    logic [3:0]  err_code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    seqtrk_top dut (
        .clk         (clk),
        .rst         (rst),
        .seq_en      (seq_en),
        .ctl_word    (ctl_word),
        .more_frag   (more_frag),
        .retry_flag  (retry_flag),
        .frag_flag   (frag_flag),
        .reasm_count (reasm_count),
        .err         (err),
        .err_code    (err_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input int seq, input int frag, input logic more, input logic rty,
                        input logic [3:0] exp_code, input string req);
        logic [15:0] w;
        w = {seq[11:0], frag[3:0]};
        @(negedge clk);
        seq_en     = 1'b1;
        ctl_word   = w;
        more_frag  = more;
        retry_flag = rty;
        @(negedge clk);
        seq_en = 1'b0;
        chk({req, " code"}, 32'(err_code), 32'(exp_code));
        chk({req, " err"}, 32'(err), 32'(exp_code != 4'b0000));
        chk({req, " R2 count"}, 32'(reasm_count), 32'(w));
        chk({req, " R3 flag"}, 32'(frag_flag), 32'(more || (frag != 0)));
    endtask

    task automatic t_reset();
        rst = 1'b1; seq_en = 1'b0; ctl_word = '0; more_frag = 1'b0; retry_flag = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 count", 32'(reasm_count), 0);
        chk("R1 flag", 32'(frag_flag), 0);
        chk("R1 err", 32'(err), 0);
        chk("R1 code", 32'(err_code), 0);
    endtask

    task automatic t_basic_and_hold();
        send(5, 0, 1'b0, 1'b0, 4'b0000, "R3 single frame");
        ctl_word = 16'hFFFF; more_frag = 1'b1; retry_flag = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 idle count", 32'(reasm_count), 32'h0050);
        chk("R2 idle flag", 32'(frag_flag), 0);
        chk("R2 idle code", 32'(err_code), 0);
    endtask

    task automatic t_chain_retry();
        send(6, 0, 1'b1, 1'b0, 4'b0000, "R3 chain start");
        send(6, 1, 1'b1, 1'b0, 4'b0000, "R5 chain next");
        send(6, 2, 1'b0, 1'b0, 4'b0000, "R5 chain last");
        send(6, 2, 1'b0, 1'b1, 4'b0000, "R4 retry match");
        send(6, 1, 1'b0, 1'b1, 4'b0111, "R4 retry mismatch");
    endtask

    task automatic t_order_errors();
        send(7, 3, 1'b0, 1'b0, 4'b0110, "R5 no continuation");
        send(8, 0, 1'b1, 1'b0, 4'b0000, "R9 new sequence");
        send(8, 2, 1'b1, 1'b0, 4'b0110, "R5 skipped fragment");
        send(9, 0, 1'b0, 1'b0, 4'b0101, "R6 early restart");
        send(8, 1, 1'b0, 1'b0, 4'b0000, "R9 history kept");
    endtask

    task automatic t_wrap();
        send(0, 0, 1'b0, 1'b0, 4'b1001, "R8 early wrap");
        send(4095, 0, 1'b0, 1'b0, 4'b0000, "R8 reach max");
        send(0, 0, 1'b0, 1'b0, 4'b0000, "R8 legal wrap");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 16; i++)
            send(1, i, 1'b1, 1'b0, 4'b0000, "R7 sixteen fragments");
        send(0, 0, 1'b0, 1'b0, 4'b1000, "R10 overflow beats restart and wrap");
        send(2, 0, 1'b0, 1'b1, 4'b0111, "R10 retry beats overflow");
    endtask

    initial begin
        t_reset();
        t_basic_and_hold();
        t_chain_retry();
        t_order_errors();
        t_wrap();
        t_overflow();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule